// File: doc/BRIEF.md
# Right-Edge Distance Unit for Raster Lines

A raster stream delivers pixels left to right, so a distance that looks toward the right-hand neighbour of each pixel cannot be formed while the line is still arriving. This unit collects one line of 8-bit gray pixels into a shift buffer. Once the last pixel of the line has been stored, it copies the line in one cycle into a second buffer with the byte order inverted. It then walks that buffer from the rightmost pixel toward the leftmost, one pixel per clock.

For each pixel the unit takes the absolute gray-level difference to the pixel directly on its right. The rightmost pixel has no right neighbour, so it is compared with itself. That difference drives a run counter. The counter clears when the difference is under an edge threshold (32 by default). It steps up by one, saturating at its maximum, when the difference is over the threshold. It holds its value when the difference equals the threshold exactly. The count reached at each pixel is that pixel's right distance. It is sent out as a short stream tagged with the pixel index, and it is also written into a result buffer that downstream logic can read by index.

Capture uses two alternating line buffers. The next line can arrive while the previous one is being copied and scanned, so lines sent back to back are all processed at full pixel rate.

Top module: `redge_dist`

## Requirements
- R1: While reset is applied and just after it is released, `sc_vld`, `res_vld` and `res_new` are all 0.
- R2: A line is captured only from a pixel cycle (`px_vld`=1) with `px_sol`=1. Valid pixels that arrive before any start of line, or after the LINE_LEN-th pixel of a line and before the next start of line, produce no output.
- R3: A start of line that arrives before the current line is complete throws away the partial line. The pixel that carries `px_sol` becomes pixel 0 of the new line.
- R4: The rightmost pixel (index LINE_LEN-1) is compared with itself, so its right distance is always 0.
- R5: Walking from index LINE_LEN-1 down to 0, with k = |p[i] - p[i+1]|: k < EDGE_THR clears the count to 0, and k > EDGE_THR adds one to the count, saturating at 2^DIST_W-1. The count after this update is the result for pixel i.
- R6: A difference exactly equal to EDGE_THR leaves the count unchanged.
- R7: Results come out one per clock with `sc_vld`=1, in descending index order from LINE_LEN-1 to 0, and `sc_idx` gives the pixel index.
- R8: If the previous line has finished, the result for index LINE_LEN-1 appears at the second rising edge after the edge that samples the line's last pixel. If the previous line is still being scanned, it appears on the edge right after that line's index-0 result.
- R9: Lines sent back to back with no idle cycles are all processed, in order, with correct results.
- R10: `res_new` pulses for one cycle together with the index-0 result. `res_vld` is 0 while a line is being written into the result buffer and 1 from its completion until the next line's first result. While `res_vld` is 1, `rd_dist` returns the stored distance of pixel `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_vld | input | 1 | Pixel valid |
| px_sol | input | 1 | Start of line, qualified by px_vld |
| px_data | input | 8 | Gray pixel value |
| rd_idx | input | $clog2(LINE_LEN) | Result buffer read index |
| sc_vld | output | 1 | Streamed result valid |
| sc_idx | output | $clog2(LINE_LEN) | Pixel index of the streamed result |
| sc_dist | output | DIST_W | Streamed right distance |
| res_vld | output | 1 | Result buffer holds a complete line |
| res_new | output | 1 | One-cycle pulse when a line completes |
| rd_dist | output | DIST_W | Stored distance at rd_idx |

## Verification
The first streamed result of a line is due two edges after the edge that samples the line's last pixel. If the scan of the previous line is still running, it is due one edge after that line's index-0 result. Each following result is due exactly one edge later. The bench records the sampling edge of every completing pixel from a cycle counter and derives the due edge of each result from that rule. It then compares index, distance and flags at the falling edge after exactly that edge, and treats any result appearing on another edge as an error. Result-buffer reads are done while idle after `res_new`, with the combinational read data sampled a short delay after `rd_idx` changes.

// File: rtl/redge_pkg.sv
package redge_pkg;
  localparam int PIX_W = 8;
  typedef logic [PIX_W-1:0] pix_t;

  // gray-level absolute difference
  function automatic pix_t gray_absdiff(input pix_t a, input pix_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/redge_capture.sv
module redge_capture
  import redge_pkg::*;
#(
  parameter int LINE_LEN = 32,
  localparam int CNT_W = $clog2(LINE_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   px_vld,
  input  logic                   px_sol,
  input  pix_t                   px_data,
  input  logic                   take,
  output logic                   line_rdy,
  output pix_t [LINE_LEN-1:0]    line_out
);

  pix_t [1:0][LINE_LEN-1:0] bank_q, bank_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             act_q, act_d;
  logic             wsel_q, wsel_d;
  logic             rsel_q, rsel_d;
  logic [1:0]       full_q, full_d;
  logic             accept;

  // a pixel is stored when it opens a line or continues an open one
  assign accept = px_vld && (px_sol || act_q);

  always_comb begin
    bank_d  = bank_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    wsel_d  = wsel_q;
    rsel_d  = rsel_q;
    full_d  = full_q;
    cnt_inc = px_sol ? CNT_W'(1) : (cnt_q + CNT_W'(1));
    if (accept) begin
      // newest pixel in byte 0, older ones move up one byte
      bank_d[wsel_q] = {bank_q[wsel_q][LINE_LEN-2:0], px_data};
      cnt_d          = cnt_inc;
      act_d          = 1'b1;
      if (cnt_inc == CNT_W'(LINE_LEN)) begin
        act_d          = 1'b0;
        full_d[wsel_q] = 1'b1;
        wsel_d         = ~wsel_q;
      end
    end
    if (take) begin
      full_d[rsel_q] = 1'b0;
      rsel_d         = ~rsel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      bank_q <= bank_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      wsel_q <= 1'b0;
      rsel_q <= 1'b0;
      full_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      wsel_q <= wsel_d;
      rsel_q <= rsel_d;
      full_q <= full_d;
    end
  end

  assign line_rdy = full_q[rsel_q];
  assign line_out = bank_q[rsel_q];

endmodule

// File: rtl/redge_reverse.sv
module redge_reverse
  import redge_pkg::*;
#(
  parameter int LINE_LEN = 32
) (
  input  logic                clk,
  input  logic                take,
  input  pix_t [LINE_LEN-1:0] line_in,
  output pix_t [LINE_LEN-1:0] rev_out
);

  pix_t [LINE_LEN-1:0] rev_q;

  // the shift buffer holds pixel i at byte LINE_LEN-1-i; invert the order
  for (genvar k = 0; k < LINE_LEN; k++) begin : g_copy
    always_ff @(posedge clk) begin
      if (take) begin
        rev_q[k] <= line_in[LINE_LEN-1-k];
      end
    end
  end

  assign rev_out = rev_q;

endmodule

// File: rtl/redge_scan.sv
module redge_scan
  import redge_pkg::*;
#(
  parameter int LINE_LEN = 32,
  parameter int EDGE_THR = 32,
  parameter int DIST_W   = 8,
  localparam int IDX_W   = $clog2(LINE_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  pix_t [LINE_LEN-1:0] rev_in,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic                can_start,
  output logic                sc_vld,
  output logic [IDX_W-1:0]    sc_idx,
  output logic [DIST_W-1:0]   sc_dist,
  output logic                res_vld,
  output logic                res_new,
  output logic [DIST_W-1:0]   rd_dist
);

  localparam logic [IDX_W-1:0]  LAST    = IDX_W'(LINE_LEN - 1);
  localparam logic [DIST_W-1:0] RUN_MAX = '1;
  localparam pix_t              THR     = PIX_W'(EDGE_THR);

  logic                busy_q, busy_d;
  logic [IDX_W-1:0]    idx_q, idx_d, nb_idx;
  logic [DIST_W-1:0]   run_q, run_d, run_nx;
  logic                vld_q, vld_d, rv_q, rv_d, new_q, new_d;
  logic [IDX_W-1:0]    oidx_q, oidx_d;
  logic [DIST_W-1:0]   odist_q, odist_d;
  logic [DIST_W-1:0]   dbuf_q [LINE_LEN];
  pix_t                cur_px, nb_px, kdiff;

  // right neighbour; the rightmost pixel uses itself
  assign nb_idx = (idx_q == LAST) ? idx_q : (idx_q + IDX_W'(1));
  assign cur_px = rev_in[idx_q];
  assign nb_px  = rev_in[nb_idx];
  assign kdiff  = gray_absdiff(cur_px, nb_px);

  always_comb begin
    if (kdiff < THR) begin
      run_nx = '0;
    end else if (kdiff > THR) begin
      run_nx = (run_q == RUN_MAX) ? run_q : (run_q + DIST_W'(1));
    end else begin
      run_nx = run_q;
    end
  end

  assign can_start = !busy_q || (idx_q == '0);

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    run_d   = run_q;
    rv_d    = rv_q;
    vld_d   = 1'b0;
    new_d   = 1'b0;
    oidx_d  = oidx_q;
    odist_d = odist_q;
    if (busy_q) begin
      run_d   = run_nx;
      vld_d   = 1'b1;
      oidx_d  = idx_q;
      odist_d = run_nx;
      if (idx_q == LAST) begin
        rv_d = 1'b0;
      end
      if (idx_q == '0) begin
        busy_d = 1'b0;
        rv_d   = 1'b1;
        new_d  = 1'b1;
      end else begin
        idx_d = idx_q - IDX_W'(1);
      end
    end
    if (start) begin
      busy_d = 1'b1;
      idx_d  = LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      run_q   <= '0;
      vld_q   <= 1'b0;
      rv_q    <= 1'b0;
      new_q   <= 1'b0;
      oidx_q  <= '0;
      odist_q <= '0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      run_q   <= run_d;
      vld_q   <= vld_d;
      rv_q    <= rv_d;
      new_q   <= new_d;
      oidx_q  <= oidx_d;
      odist_q <= odist_d;
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q) begin
      dbuf_q[idx_q] <= run_nx;
    end
  end

  assign rd_dist = (int'(rd_idx) < LINE_LEN) ? dbuf_q[rd_idx] : '0;
  assign sc_vld  = vld_q;
  assign sc_idx  = oidx_q;
  assign sc_dist = odist_q;
  assign res_vld = rv_q;
  assign res_new = new_q;

endmodule

// File: rtl/redge_dist.sv
module redge_dist
  import redge_pkg::*;
#(
  parameter int LINE_LEN = 32,
  parameter int EDGE_THR = 32,
  parameter int DIST_W   = 8,
  localparam int IDX_W   = $clog2(LINE_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              px_vld,
  input  logic              px_sol,
  input  logic [7:0]        px_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              sc_vld,
  output logic [IDX_W-1:0]  sc_idx,
  output logic [DIST_W-1:0] sc_dist,
  output logic              res_vld,
  output logic              res_new,
  output logic [DIST_W-1:0] rd_dist
);

  logic                rst_s1_q, rst_s2_q;
  logic                line_rdy, can_start, take;
  pix_t [LINE_LEN-1:0] cap_line, rev_line;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign take = line_rdy && can_start;

  redge_capture #(.LINE_LEN(LINE_LEN)) i_capture (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .px_vld   (px_vld),
    .px_sol   (px_sol),
    .px_data  (px_data),
    .take     (take),
    .line_rdy (line_rdy),
    .line_out (cap_line)
  );

  redge_reverse #(.LINE_LEN(LINE_LEN)) i_reverse (
    .clk     (clk),
    .take    (take),
    .line_in (cap_line),
    .rev_out (rev_line)
  );

  redge_scan #(
    .LINE_LEN (LINE_LEN),
    .EDGE_THR (EDGE_THR),
    .DIST_W   (DIST_W)
  ) i_scan (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .start     (take),
    .rev_in    (rev_line),
    .rd_idx    (rd_idx),
    .can_start (can_start),
    .sc_vld    (sc_vld),
    .sc_idx    (sc_idx),
    .sc_dist   (sc_dist),
    .res_vld   (res_vld),
    .res_new   (res_new),
    .rd_dist   (rd_dist)
  );

endmodule

// File: rtl/redge_dist_chk.sv
module redge_dist_chk #(
  parameter int LINE_LEN = 32,
  parameter int DIST_W   = 8,
  localparam int IDX_W   = $clog2(LINE_LEN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sc_vld,
  input logic [IDX_W-1:0]  sc_idx,
  input logic [DIST_W-1:0] sc_dist,
  input logic              res_vld,
  input logic              res_new
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINE_LEN - 1);

  p_last_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_vld && sc_idx == LAST) |-> (sc_dist == '0));

  p_run_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_vld && sc_idx != '0) |=>
      (sc_dist == '0 || sc_dist == $past(sc_dist) ||
       sc_dist == DIST_W'($past(sc_dist) + 1'b1)));

  p_desc_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_vld && sc_idx != '0) |=> (sc_vld && sc_idx == IDX_W'($past(sc_idx) - 1'b1)));

  p_scan_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sc_vld || sc_idx == '0) |=> (!sc_vld || sc_idx == LAST));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_new |-> (sc_vld && sc_idx == '0 && res_vld));

  p_busy_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_vld && sc_idx != '0) |-> !res_vld);

endmodule

bind redge_dist redge_dist_chk #(.LINE_LEN(LINE_LEN), .DIST_W(DIST_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sc_vld  (sc_vld),
  .sc_idx  (sc_idx),
  .sc_dist (sc_dist),
  .res_vld (res_vld),
  .res_new (res_new)
);

// File: tb/test_redge_dist.sv
module test_redge_dist;
  localparam int CLK_PER = 10;
  localparam int LEN     = 32;
  localparam int THR     = 32;
  localparam int IW      = $clog2(LEN);

  logic          clk;
  logic          rst_n;
  logic          px_vld, px_sol;
  logic [7:0]    px_data;
  logic [IW-1:0] rd_idx;
  logic          sc_vld, res_vld, res_new;
  logic [IW-1:0] sc_idx;
  logic [7:0]    sc_dist, rd_dist;

  redge_dist #(.LINE_LEN(LEN), .EDGE_THR(THR), .DIST_W(8)) i_redge_dist (
    .clk(clk), .rst_n(rst_n), .px_vld(px_vld), .px_sol(px_sol), .px_data(px_data),
    .rd_idx(rd_idx), .sc_vld(sc_vld), .sc_idx(sc_idx), .sc_dist(sc_dist),
    .res_vld(res_vld), .res_new(res_new), .rd_dist(rd_dist)
  );

  int n_chk, n_fail;
  int cyc;
  bit mon_on;
  int exp_q [64][LEN];
  int start_q [64];
  int head, tail, pos, prev_end, done_lines;
  int last_exp [LEN];
  logic [7:0] m_line [LEN];
  logic [7:0] src [LEN];
  int m_cnt;
  bit m_act;

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;
  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // model of the line rule from R2/R3, computing R4/R5/R6 results and R8 timing
  task automatic enqueue(input int c_edge);
    int run, k, nb, st;
    run = 0;
    for (int p = LEN - 1; p >= 0; p--) begin
      nb = (p == LEN - 1) ? int'(m_line[p]) : int'(m_line[p+1]);
      k = int'(m_line[p]) - nb;
      if (k < 0) k = -k;
      if (k < THR) run = 0;
      else if (k > THR) run = (run == 255) ? 255 : run + 1;
      exp_q[tail % 64][p] = run;
    end
    st = (c_edge + 2 > prev_end + 1) ? c_edge + 2 : prev_end + 1;
    start_q[tail % 64] = st;
    prev_end = st + LEN - 1;
    tail++;
  endtask

  task automatic put(input bit sol, input logic [7:0] d);
    @(negedge clk);
    px_vld = 1'b1; px_sol = sol; px_data = d;
    if (sol) begin m_act = 1'b1; m_cnt = 0; end
    if (m_act) begin
      m_line[m_cnt] = d;
      m_cnt++;
      if (m_cnt == LEN) begin m_act = 1'b0; enqueue(cyc + 1); end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      px_vld = 1'b0; px_sol = 1'b0; px_data = 8'h00;
    end
  endtask

  task automatic send_src(input int max_gap);
    for (int i = 0; i < LEN; i++) begin
      put(i == 0, src[i]);
      if (max_gap > 0) idle($urandom_range(0, max_gap));
    end
  endtask

  task automatic rd_all(input string req);
    chk(res_vld, {req, " res_vld before read"}, res_vld, 1);
    for (int k = 0; k < LEN; k++) begin
      @(negedge clk);
      rd_idx = IW'(k);
      #1;
      chk(int'(rd_dist) == last_exp[k], req, rd_dist, last_exp[k]);
    end
  endtask

  // result monitor: R7 order, R5 values, R8 due edge, R10 flags, R2 no stray output
  always @(negedge clk) begin
    if (mon_on) begin
      if (head != tail && cyc == start_q[head % 64] + pos) begin
        chk(sc_vld, "R8 result on due edge", sc_vld, 1);
        chk(int'(sc_idx) == LEN - 1 - pos, "R7 index order", sc_idx, LEN - 1 - pos);
        chk(int'(sc_dist) == exp_q[head % 64][LEN - 1 - pos], "R5 streamed distance",
            sc_dist, exp_q[head % 64][LEN - 1 - pos]);
        if (pos == LEN - 1) begin
          chk(res_new && res_vld, "R10 completion flags", {res_new, res_vld}, 3);
          for (int k = 0; k < LEN; k++) last_exp[k] = exp_q[head % 64][k];
          head++; pos = 0; done_lines++;
        end else begin
          chk(!res_new && !res_vld, "R10 flags during scan", {res_new, res_vld}, 0);
          pos++;
        end
      end else if (sc_vld || res_new) begin
        chk(1'b0, "R2 unexpected output", {sc_vld, res_new}, 0);
      end
    end
  end

  initial begin
    #(CLK_PER * 150000);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base, v;
    void'($urandom(32'd20517));
    rst_n = 1'b0; px_vld = 0; px_sol = 0; px_data = 0; rd_idx = '0;
    m_act = 0; m_cnt = 0; head = 0; tail = 0; pos = 0; prev_end = 0; done_lines = 0;
    repeat (3) @(negedge clk);
    chk(!sc_vld && !res_vld && !res_new, "R1 outputs in reset", {sc_vld, res_vld, res_new}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sc_vld && !res_vld && !res_new, "R1 outputs after reset", {sc_vld, res_vld, res_new}, 0);
    mon_on = 1'b1;

    // R2: valid pixels with no start of line are ignored
    for (int i = 0; i < 40; i++) put(1'b0, 8'($urandom_range(0, 255)));
    idle(LEN + 8);
    chk(done_lines == 0 && !res_vld, "R2 pixels before start ignored", done_lines, 0);

    // R6: differences of exactly 32 mixed with larger and smaller ones
    begin
      int dl [8] = '{40, -32, 50, -33, 31, -45, 32, -43};
      v = 128;
      for (int p = LEN - 1; p >= 0; p--) begin
        src[p] = 8'(v);
        v = v + dl[(LEN - 1 - p) % 8];
      end
    end
    send_src(0);
    idle(LEN + 6);
    chk(done_lines == 1, "R6 line completed", done_lines, 1);
    rd_all("R6 equal-threshold hold");

    // R5: every neighbour differs by 255, count climbs to LEN-1 at pixel 0
    for (int p = 0; p < LEN; p++) src[p] = (p % 2 == 0) ? 8'd0 : 8'd255;
    send_src(0);
    idle(LEN + 6);
    @(negedge clk); rd_idx = '0; #1;
    chk(int'(rd_dist) == LEN - 1, "R5 count reaches line length", rd_dist, LEN - 1);
    rd_all("R10 buffer read");

    // R4: last pixel far from its left neighbour still gets 0
    for (int p = 0; p < LEN; p++) src[p] = 8'd200;
    src[LEN-1] = 8'd0;
    send_src(0);
    idle(LEN + 6);
    @(negedge clk); rd_idx = IW'(LEN - 1); #1;
    chk(rd_dist == 8'd0, "R4 rightmost pixel distance", rd_dist, 0);
    @(negedge clk); rd_idx = IW'(LEN - 2); #1;
    chk(rd_dist == 8'd1, "R4 pixel left of rightmost", rd_dist, 1);

    // R3: partial line discarded, trailing pixels ignored
    base = done_lines;
    for (int i = 0; i < 10; i++) put(i == 0, 8'($urandom_range(0, 255)));
    for (int p = 0; p < LEN; p++) src[p] = 8'($urandom_range(0, 255));
    send_src(0);
    for (int i = 0; i < 7; i++) put(1'b0, 8'($urandom_range(0, 255)));
    idle(2 * LEN);
    chk(done_lines == base + 1, "R3 only restarted line processed", done_lines - base, 1);
    rd_all("R3 restarted line contents");

    // R8: gapped pixel stream
    for (int p = 0; p < LEN; p++) src[p] = 8'($urandom_range(0, 255));
    send_src(3);
    idle(LEN + 6);

    // R9: back-to-back lines, no idle cycles
    base = done_lines;
    for (int l = 0; l < 6; l++) begin
      for (int p = 0; p < LEN; p++)
        src[p] = ($urandom_range(0, 1) == 1) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(100, 140));
      send_src(0);
    end
    idle(3 * LEN);
    chk(done_lines == base + 6, "R9 back-to-back lines done", done_lines - base, 6);

    // mixed random traffic
    for (int l = 0; l < 20; l++) begin
      for (int p = 0; p < LEN; p++) src[p] = 8'($urandom_range(0, 255));
      send_src($urandom_range(0, 1));
      idle($urandom_range(0, LEN / 2));
    end
    idle(3 * LEN);
    chk(head == tail, "R9 all lines drained", tail - head, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule